// File: doc/BRIEF.md
# Oversampled Serial Receive Bit Recovery

This block recovers the bits of a position-encoder reply frame from a raw serial data line. The line is not related to the local clock, so it first passes through a two-stage synchronizer. A one-cycle oversample strobe then samples it at eight times the interface bit rate. When enabled, the block waits for a rising edge on the idle-low line. That edge marks the first sample of the start group. The start group itself is thrown away. Each later group of eight samples gives one data bit, read from a fixed position within the group, and the bit is delivered with a strobe and a running count.

Each bit is delivered as soon as its group reaches the read position, so back-to-back frames in continuous mode never wait for a post-processing pass. After the expected number of data bits, the block signals the end of the frame. It then ignores the line for two bit periods, because the encoder may keep the line driven high for that long. After that window it re-arms by itself if it is still enabled. A timeout counted in sample groups from arming catches a frame that never completes.

Top module: `os_bit_recover`

## Requirements
- R1: While reset is high, and in the first cycle after it, `bit_valid`, `frame_done` and `err_timeout` are low. `bit_count` reads 0 after reset.
- R2: Once armed, a frame starts at the first strobe where the sampled line is 1 and the sample at the previous strobe was 0. A line that is already high when the block arms starts nothing until it has gone low and risen again.
- R3: Samples are numbered 0 to 7 within each group, where sample 0 of the start group is the strobe that saw the rising edge. Each data bit takes the line value at sample 3 only, whatever the other seven samples hold. The bit appears on `bit_out` with `bit_valid` high for one cycle, in the cycle after that strobe.
- R4: The start group raises no `bit_valid`. Data groups 1 to `exp_bits` each raise exactly one `bit_valid`, and `bit_count` then equals the group number, so the first data bit has count 1. No other strobe raises `bit_valid`.
- R5: `frame_done` pulses in the same cycle as the `bit_valid` of data bit number `exp_bits`.
- R6: For the 16 strobes after the one that ends a frame, no line activity starts a frame.
- R7: If `tmo_groups` is non-zero, `err_timeout` pulses at strobe number 8*`tmo_groups`-1, counted from 0 at the first strobe after arming, unless the frame has already ended. The frame is then dropped: the block delivers no further bits and enters the same 16-strobe lockout as R6. A value of 0 turns the timeout off.
- R8: If the end of the frame and the timeout fall on the same strobe, only `frame_done` is raised.
- R9: Dropping `enable` during arming or reception stops the block at once. No further `bit_valid`, `frame_done` or `err_timeout` is raised until it is enabled again.
- R10: If `enable` stays high, the block re-arms by itself after the lockout. The next frame is then received with no other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_raw | input | 1 | Asynchronous serial data from the line receiver |
| os_tick | input | 1 | One-cycle oversample strobe, eight per bit period |
| enable | input | 1 | Arms the receiver; low returns it to idle |
| exp_bits | input | CNT_W (6) | Data bits expected after the start bit |
| tmo_groups | input | TMO_W (8) | Timeout in sample groups from arming; 0 turns it off |
| bit_out | output | 1 | Recovered data bit |
| bit_valid | output | 1 | One-cycle strobe qualifying `bit_out` |
| bit_count | output | CNT_W (6) | Number of the bit just delivered, starting at 1 |
| frame_done | output | 1 | One-cycle pulse with the last expected bit |
| err_timeout | output | 1 | One-cycle pulse when the frame timeout expires |

## Verification
The end of a frame and the expiry of the timeout can fall on the same oversample strobe. The bench provokes this by arming with a timeout of three groups, holding the line low for four strobes and then sending a two-bit frame. The final sample strobe is then strobe 23, which is also the strobe where three groups expire. The expected result is `frame_done` with the last bit and no error. The same setup with the start edge one strobe later must give the error alone, after the first bit and before the second.

// File: rtl/obr_pkg.sv
package obr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RECV = 2'd2,
        ST_HOLD = 2'd3
    } obr_state_e;

    typedef struct packed {
        logic vld;
        logic dat;
        logic done;
        logic err;
    } obr_evt_t;

    localparam obr_evt_t EVT_NONE = '{vld: 1'b0, dat: 1'b0, done: 1'b0, err: 1'b0};

    function automatic int pick_index(input int osr);
        return (osr / 2) - 1;
    endfunction

    function automatic logic timer_runs(input obr_state_e st);
        return (st == ST_ARM) || (st == ST_RECV);
    endfunction

endpackage

// File: rtl/obr_sync.sv
module obr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/obr_group_timer.sv
module obr_group_timer #(
    parameter int OSR   = 8,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    localparam int PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

    logic [PH_W-1:0]  ph;
    logic [TMO_W-1:0] groups;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph     <= '0;
            groups <= '0;
        end else if (tick) begin
            ph <= ph + 1'b1;
            if (ph == PH_LAST) groups <= groups + 1'b1;
        end
    end

    assign expire = run && tick && (ph == PH_LAST) && (limit != '0)
                    && (groups == limit - 1'b1);
endmodule

// File: rtl/obr_frame_ctrl.sv
module obr_frame_ctrl
    import obr_pkg::*;
#(
    parameter int OSR   = 8,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_s,
    input  logic             os_tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] exp_bits,
    input  logic             tmo_expire,
    output obr_state_e       state,
    output obr_evt_t         evt,
    output logic [CNT_W-1:0] bit_count
);
    localparam int PH_W = $clog2(OSR);
    localparam int HOLD_TICKS = 2 * OSR;
    localparam int HOLD_W = $clog2(HOLD_TICKS);
    localparam logic [PH_W-1:0]   PH_PICK  = PH_W'(pick_index(OSR));
    localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(OSR - 1);
    localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLD_TICKS - 1);

    obr_state_e        st;
    logic              last_s;
    logic [PH_W-1:0]   phase;
    logic [CNT_W-1:0]  grp;
    logic [HOLD_W-1:0] hold_cnt;
    logic              pick_now;
    logic              last_grp;

    assign pick_now = os_tick && (phase == PH_PICK);
    assign last_grp = (grp == exp_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            last_s    <= 1'b0;
            phase     <= '0;
            grp       <= '0;
            hold_cnt  <= '0;
            evt       <= EVT_NONE;
            bit_count <= '0;
        end else begin
            evt <= EVT_NONE;
            if (os_tick) last_s <= rx_s;
            unique case (st)
                ST_IDLE: begin
                    if (enable) st <= ST_ARM;
                end
                ST_ARM: begin
                    if (!enable) begin
                        st <= ST_IDLE;
                    end else if (tmo_expire) begin
                        evt.err  <= 1'b1;
                        st       <= ST_HOLD;
                        hold_cnt <= '0;
                    end else if (os_tick && rx_s && !last_s) begin
                        st        <= ST_RECV;
                        phase     <= PH_W'(1);
                        grp       <= '0;
                        bit_count <= '0;
                    end
                end
                ST_RECV: begin
                    if (!enable) begin
                        st <= ST_IDLE;
                    end else if (os_tick) begin
                        phase <= phase + 1'b1;
                        if (phase == PH_LAST) grp <= grp + 1'b1;
                        if (pick_now && grp != '0) begin
                            evt.vld   <= 1'b1;
                            evt.dat   <= rx_s;
                            bit_count <= grp;
                        end
                        if (pick_now && last_grp) begin
                            evt.done <= 1'b1;
                            st       <= ST_HOLD;
                            hold_cnt <= '0;
                        end else if (tmo_expire) begin
                            evt.err  <= 1'b1;
                            evt.vld  <= 1'b0;
                            st       <= ST_HOLD;
                            hold_cnt <= '0;
                        end
                    end
                end
                ST_HOLD: begin
                    if (os_tick) begin
                        if (hold_cnt == HOLD_END) st <= enable ? ST_ARM : ST_IDLE;
                        else                      hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign state = st;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !evt.vld && !evt.done && !evt.err); // R1
    AST_PICK_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        evt.vld |-> $past(os_tick)); // R3
    AST_VALID_SPACED: assert property (@(posedge clk) disable iff (rst)
        evt.vld |=> !evt.vld); // R4
    AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (rst)
        (evt.done && exp_bits != '0) |-> evt.vld && bit_count == exp_bits); // R5
    AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && $past(st == ST_HOLD)) |-> !evt.vld && !evt.done); // R6
    AST_DONE_OVER_ERR: assert property (@(posedge clk) disable iff (rst)
        !(evt.done && evt.err)); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st == ST_IDLE)) |-> !evt.vld && !evt.err); // R9
endmodule

// File: rtl/os_bit_recover.sv
module os_bit_recover
    import obr_pkg::*;
#(
    parameter int OSR   = 8,
    parameter int CNT_W = 6,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_raw,
    input  logic             os_tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] exp_bits,
    input  logic [TMO_W-1:0] tmo_groups,
    output logic             bit_out,
    output logic             bit_valid,
    output logic [CNT_W-1:0] bit_count,
    output logic             frame_done,
    output logic             err_timeout
);
    logic       rx_s;
    logic       tmo_expire;
    obr_state_e state;
    obr_evt_t   evt;

    obr_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_raw),
        .dout (rx_s)
    );

    obr_group_timer #(.OSR(OSR), .TMO_W(TMO_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (timer_runs(state)),
        .tick   (os_tick),
        .limit  (tmo_groups),
        .expire (tmo_expire)
    );

    obr_frame_ctrl #(.OSR(OSR), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rx_s       (rx_s),
        .os_tick    (os_tick),
        .enable     (enable),
        .exp_bits   (exp_bits),
        .tmo_expire (tmo_expire),
        .state      (state),
        .evt        (evt),
        .bit_count  (bit_count)
    );

    assign bit_out     = evt.dat;
    assign bit_valid   = evt.vld;
    assign frame_done  = evt.done;
    assign err_timeout = evt.err;
endmodule

// File: tb/os_bit_recover_tb.sv
module os_bit_recover_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_raw = 1'b0;
    logic       os_tick = 1'b0;
    logic       enable = 1'b0;
    logic [5:0] exp_bits = '0;
    logic [7:0] tmo_groups = '0;
    logic       bit_out, bit_valid, frame_done, err_timeout;
    logic [5:0] bit_count;

    int total = 0;
    int bad = 0;
    logic o_v, o_b, o_d, o_e;
    logic [5:0] o_c;

    always #2 clk = ~clk;

    os_bit_recover u_dut (
        .clk(clk), .rst(rst), .rx_raw(rx_raw), .os_tick(os_tick),
        .enable(enable), .exp_bits(exp_bits), .tmo_groups(tmo_groups),
        .bit_out(bit_out), .bit_valid(bit_valid), .bit_count(bit_count),
        .frame_done(frame_done), .err_timeout(err_timeout)
    );

    typedef struct packed {
        logic [3:0]  pre;
        logic [5:0]  n;
        logic [15:0] d;
        logic        g;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{pre: 4'd2, n: 6'd8,  d: 16'h0025, g: 1'b0},
        '{pre: 4'd1, n: 6'd16, d: 16'hF00F, g: 1'b1},
        '{pre: 4'd5, n: 6'd1,  d: 16'h0001, g: 1'b1},
        '{pre: 4'd3, n: 6'd13, d: 16'h1234, g: 1'b0},
        '{pre: 4'd1, n: 6'd2,  d: 16'h0002, g: 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input logic v);
        @(negedge clk); rx_raw = v; os_tick = 1'b0;
        @(negedge clk);
        @(negedge clk); os_tick = 1'b1;
        @(negedge clk); os_tick = 1'b0;
        o_v = bit_valid; o_b = bit_out; o_c = bit_count; o_d = frame_done; o_e = err_timeout;
    endtask

    task automatic rearm();
        @(negedge clk); enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_frame(input int pre, input int n, input logic [15:0] d, input logic g);
        for (int i = 0; i < pre; i++) begin
            tick(1'b0);
            check("R2 no bit before start edge", o_v, 0);
        end
        for (int j = 0; j < 8; j++) begin
            tick(1'b1);
            check("R4 start group silent", o_v, 0);
        end
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < 8; j++) begin
                tick((g && j != 3) ? ~d[k] : d[k]);
                if (j == 3) begin
                    check("R3 valid at sample 3", o_v, 1);
                    check("R3 bit value", o_b, d[k]);
                    check("R4 bit count", o_c, k + 1);
                    check("R5 done with last bit", o_d, (k + 1 == n));
                    check("R8 no error on good frame", o_e, 0);
                end else begin
                    check("R4 no valid off sample 3", o_v, 0);
                end
            end
        end
    endtask

    task automatic lockout_tail();
        for (int i = 0; i < 12; i++) begin
            tick(1'b1);
            check("R6 lockout ignores line", o_v, 0);
        end
        for (int i = 0; i < 4; i++) begin
            tick(1'b1);
            check("R6 high line after lockout starts nothing", o_v, 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", bit_valid, 0);
        check("R1 done in reset", frame_done, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", bit_valid, 0);
        check("R1 error after reset", err_timeout, 0);
        check("R1 count after reset", bit_count, 0);

        enable = 1'b1;
        tmo_groups = 8'd0;
        for (int v = 0; v < NV; v++) begin
            exp_bits = VECS[v].n;
            send_frame(int'(VECS[v].pre), int'(VECS[v].n), VECS[v].d, VECS[v].g);
            lockout_tail(); // R10 re-arm without touching enable
        end

        // R8 collision: done and timeout on strobe 23
        tmo_groups = 8'd3;
        exp_bits = 6'd2;
        rearm();
        send_frame(4, 2, 16'h0003, 1'b0);
        lockout_tail();

        // R7 timeout one strobe ahead of the frame end
        rearm();
        for (int i = 0; i < 5; i++) tick(1'b0);
        for (int j = 0; j < 8; j++) tick(1'b1);
        for (int j = 0; j < 8; j++) begin
            tick(1'b1);
            if (j == 3) check("R7 first bit before timeout", o_v, 1);
        end
        tick(1'b0); check("R7 no error early", o_e, 0);
        tick(1'b0); check("R7 no error early", o_e, 0);
        tick(1'b0); check("R7 error at strobe 23", o_e, 1);
        check("R8 no done with lone error", o_d, 0);
        tick(1'b0); check("R7 second bit dropped", o_v, 0);
        for (int i = 0; i < 12; i++) begin
            tick(i[0]);
            check("R7 lockout after timeout", o_v, 0);
        end

        // R7 zero disables the timeout
        tmo_groups = 8'd0;
        rearm();
        for (int i = 0; i < 40; i++) begin
            tick(1'b0);
            if (o_e) check("R7 timeout disabled", o_e, 0);
        end
        check("R7 disabled timeout quiet", o_e, 0);

        // R9 abort mid-frame, R2 line already high at arm
        exp_bits = 6'd4;
        tick(1'b1);
        for (int j = 0; j < 7; j++) tick(1'b1);
        for (int j = 0; j < 8; j++) tick(1'b0);
        @(negedge clk); enable = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick(i[1]);
            check("R9 disabled block silent", o_v | o_d | o_e, 0);
        end
        @(negedge clk); rx_raw = 1'b1;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick(1'b1);
            check("R2 high line at arm starts nothing", o_v, 0);
        end
        send_frame(1, 4, 16'h000A, 1'b1);
        lockout_tail();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule